// File: doc/BRIEF.md
# Saturating Rounding Doubling MAC Lanes

This block is a packed signed-integer SIMD datapath. For each lane it forms the high half of a doubled product added to, or subtracted from, an accumulator, with rounding. It clamps any result that leaves the signed lane range and records the clamp in a sticky flag. The accumulator operand is the current destination vector, so the caller writes the result back over it.

One control bit picks 16-bit or 32-bit lanes. The vector is split into 64-bit chunks. Chunks inside the active byte count carry computed lanes. Chunks from the active count up to the maximum byte count come out as zero. Chunks past the maximum return the accumulator unchanged, so the destination beyond the maximum size is preserved. A request is taken on a valid strobe, and the result appears registered one cycle later.

Top module: `sat_dmac_vec`

## Requirements
- R1: In 16-bit mode (`lane_wide_i`=0) each lane result is ((acc<<15) + a*b + 2^14) >>> 15, computed at full precision, when `sub_i`=0.
- R2: When `sub_i`=1, the product is subtracted instead: ((acc<<(w-1)) - a*b + 2^(w-2)) >>> (w-1).
- R3: A shifted result that does not fit in signed w bits is clamped to the most negative lane value (0x8000 or 0x80000000) if negative, and to 0x7fff or 0x7fffffff otherwise. For w=16, a=b=-32768 with acc=0 gives 0x7fff on add and 0x8000 without clamping on subtract.
- R4: In 32-bit mode (`lane_wide_i`=1) each 32-bit lane uses the same formulas with w=32 and a 64-bit product.
- R5: Lane i of width w occupies bits [i*w+w-1 : i*w] of every operand and of the result. Lanes are independent, and lane 0 is the lowest.
- R6: `sat_flag_o` becomes 1 in the cycle after a valid request in which any lane inside the active size clamps. It then stays 1 until it is cleared.
- R7: `flag_clr_i`=1 clears `sat_flag_o` on the next edge. A valid request that clamps in the same cycle still leaves the flag set.
- R8: A 64-bit chunk k with 8k >= active bytes and 8k < maximum bytes is output as zero, and lanes in that chunk never set the flag.
- R9: A chunk k with 8k >= maximum bytes outputs its accumulator bits unchanged, and lanes in that chunk never set the flag.
- R10: `res_o` and `res_vld_o` update one cycle after `valid_i`. `res_vld_o` follows `valid_i` delayed by one cycle, and `res_o` holds its value while `valid_i` is low.
- R11: After reset `res_o`, `res_vld_o` and `sat_flag_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| sub_i | input | 1 | 1 = subtract product, 0 = add |
| lane_wide_i | input | 1 | 0 = 16-bit lanes, 1 = 32-bit lanes |
| act_bytes_i | input | BW | Active operand size in bytes, multiple of 8 |
| max_bytes_i | input | BW | Maximum vector size in bytes, multiple of 8, >= active |
| op_a_i | input | VEC_W | First multiplicand vector |
| op_b_i | input | VEC_W | Second multiplicand vector |
| acc_i | input | VEC_W | Accumulator / current destination vector |
| flag_clr_i | input | 1 | Clear the sticky saturation flag |
| res_o | output | VEC_W | Registered result vector |
| res_vld_o | output | 1 | Result valid, one cycle after request |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
Clamping is rare under uniform random operands. It needs extreme multiplicands together with a large same-sign accumulator, or both multiplicands at the most negative value. The stimulus therefore draws each 16-bit field from the two extremes a quarter of the time, and directed cases add the double-minimum product in both widths and both directions. It is also hard to show that a clamp in a zeroed or preserved chunk leaves the flag alone. Directed cases place saturating data only outside the active size, with the flag cleared first.

// File: rtl/sdm_pkg.sv
// Shared constants and types for the saturating doubling MAC vector block.
package sdm_pkg;
    localparam int CHUNK_W     = 64;
    localparam int CHUNK_BYTES = CHUNK_W / 8;

    typedef enum logic {
        LANE_HALF = 1'b0,
        LANE_WORD = 1'b1
    } lane_mode_e;

    typedef enum logic [1:0] {
        REG_CALC = 2'd0,
        REG_ZERO = 2'd1,
        REG_KEEP = 2'd2
    } chunk_region_e;
endpackage

// File: rtl/sdm_lane.sv
// One signed lane: ((acc << (W-1)) +/- a*b + 2^(W-2)) >>> (W-1), then clamp.
// Assumes W >= 4. Purely combinational, full-precision intermediate of 2W+1 bits.
module sdm_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] acc_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         sat_o
);
    localparam int SW = 2 * W + 1;
    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic signed [2*W-1:0] prod;
    logic signed [SW-1:0]  acc_sh;
    logic signed [SW-1:0]  prod_x;
    logic signed [SW-1:0]  rnd;
    logic signed [SW-1:0]  sum;
    logic signed [SW-1:0]  shifted;
    logic                  fits;

    // Fused sum, arithmetic shift and range check.
    always_comb begin
        prod    = $signed(a_i) * $signed(b_i);
        acc_sh  = $signed({{(W+1){acc_i[W-1]}}, acc_i}) <<< (W - 1);
        prod_x  = $signed({prod[2*W-1], prod});
        rnd     = $signed(SW'(1)) <<< (W - 2);
        sum     = sub_i ? (acc_sh - prod_x + rnd) : (acc_sh + prod_x + rnd);
        shifted = sum >>> (W - 1);
        fits    = (&shifted[SW-1:W-1]) || !(|shifted[SW-1:W-1]);
        sat_o   = !fits;
        if (fits)
            res_o = shifted[W-1:0];
        else
            res_o = shifted[SW-1] ? NEG_LIM : POS_LIM;
    end
endmodule

// File: rtl/sdm_chunk.sv
// One 64-bit chunk: both lane widths are built and the mode selects one.
// Assumes the chunk width is a multiple of 32.
module sdm_chunk
    import sdm_pkg::*;
(
    input  logic [CHUNK_W-1:0] a_i,
    input  logic [CHUNK_W-1:0] b_i,
    input  logic [CHUNK_W-1:0] acc_i,
    input  logic               sub_i,
    input  lane_mode_e         mode_i,
    output logic [CHUNK_W-1:0] res_o,
    output logic               sat_o
);
    localparam int NH = CHUNK_W / 16;
    localparam int NW = CHUNK_W / 32;

    logic [CHUNK_W-1:0] res_h, res_w;
    logic [NH-1:0]      sat_h;
    logic [NW-1:0]      sat_w;

    for (genvar i = 0; i < NH; i++) begin : g_half
        sdm_lane #(.W(16)) lane_i (
            .a_i  (a_i[i*16 +: 16]),
            .b_i  (b_i[i*16 +: 16]),
            .acc_i(acc_i[i*16 +: 16]),
            .sub_i(sub_i),
            .res_o(res_h[i*16 +: 16]),
            .sat_o(sat_h[i])
        );
    end

    for (genvar j = 0; j < NW; j++) begin : g_word
        sdm_lane #(.W(32)) lane_i (
            .a_i  (a_i[j*32 +: 32]),
            .b_i  (b_i[j*32 +: 32]),
            .acc_i(acc_i[j*32 +: 32]),
            .sub_i(sub_i),
            .res_o(res_w[j*32 +: 32]),
            .sat_o(sat_w[j])
        );
    end

    // Pick the lane width in use.
    always_comb begin
        res_o = (mode_i == LANE_WORD) ? res_w : res_h;
        sat_o = (mode_i == LANE_WORD) ? (|sat_w) : (|sat_h);
    end
endmodule

// File: rtl/sat_dmac_vec.sv
// Vector top: per-chunk arithmetic, tail zeroing up to the maximum size,
// pass-through beyond it, registered result and sticky saturation flag.
// Assumes byte counts are multiples of 8 with act <= max <= VEC_W/8.
module sat_dmac_vec
    import sdm_pkg::*;
#(
    parameter int VEC_W = 128,
    localparam int BW = $clog2(VEC_W / 8 + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             sub_i,
    input  logic             lane_wide_i,
    input  logic [BW-1:0]    act_bytes_i,
    input  logic [BW-1:0]    max_bytes_i,
    input  logic [VEC_W-1:0] op_a_i,
    input  logic [VEC_W-1:0] op_b_i,
    input  logic [VEC_W-1:0] acc_i,
    input  logic             flag_clr_i,
    output logic [VEC_W-1:0] res_o,
    output logic             res_vld_o,
    output logic             sat_flag_o
);
    localparam int NCH = VEC_W / CHUNK_W;

    lane_mode_e       mode;
    logic [VEC_W-1:0] res_d;
    logic [NCH-1:0]   sat_ch;
    logic             sat_any;

    assign mode = lane_mode_e'(lane_wide_i);

    for (genvar k = 0; k < NCH; k++) begin : g_chunk
        localparam logic [BW:0] BASE = (BW + 1)'(k * CHUNK_BYTES);
        logic [CHUNK_W-1:0] calc;
        logic               csat;
        chunk_region_e      region;

        sdm_chunk chunk_i (
            .a_i   (op_a_i[k*CHUNK_W +: CHUNK_W]),
            .b_i   (op_b_i[k*CHUNK_W +: CHUNK_W]),
            .acc_i (acc_i[k*CHUNK_W +: CHUNK_W]),
            .sub_i (sub_i),
            .mode_i(mode),
            .res_o (calc),
            .sat_o (csat)
        );

        // Classify the chunk against the active and maximum sizes.
        always_comb begin
            if ({1'b0, act_bytes_i} > BASE)
                region = REG_CALC;
            else if ({1'b0, max_bytes_i} > BASE)
                region = REG_ZERO;
            else
                region = REG_KEEP;
        end

        // Select chunk output and gate its saturation to active chunks.
        always_comb begin
            case (region)
                REG_CALC: res_d[k*CHUNK_W +: CHUNK_W] = calc;
                REG_ZERO: res_d[k*CHUNK_W +: CHUNK_W] = '0;
                default:  res_d[k*CHUNK_W +: CHUNK_W] = acc_i[k*CHUNK_W +: CHUNK_W];
            endcase
            sat_ch[k] = csat && (region == REG_CALC);
        end

        AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && ({1'b0, act_bytes_i} <= BASE) && ({1'b0, max_bytes_i} > BASE))
            |=> (res_o[k*CHUNK_W +: CHUNK_W] == '0)); // R8
        AST_KEEP_ACC: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && ({1'b0, max_bytes_i} <= BASE))
            |=> (res_o[k*CHUNK_W +: CHUNK_W] == $past(acc_i[k*CHUNK_W +: CHUNK_W]))); // R9
    end

    assign sat_any = |sat_ch;

    // Result and valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o     <= '0;
            res_vld_o <= 1'b0;
        end else begin
            res_vld_o <= valid_i;
            if (valid_i)
                res_o <= res_d;
        end
    end

    // Sticky flag: clear first, then a saturating request sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sat_flag_o <= 1'b0;
        else
            sat_flag_o <= (flag_clr_i ? 1'b0 : sat_flag_o) | (valid_i & sat_any);
    end

    AST_VLD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> res_vld_o); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> $stable(res_o)); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag_o && !flag_clr_i) |=> sat_flag_o); // R6
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !valid_i) |=> !sat_flag_o); // R7
endmodule

// File: tb/sat_dmac_vec_tb_top.sv
`timescale 1ns/1ps
module sat_dmac_vec_tb_top;
    localparam int VEC_W = 128;
    localparam int BW = $clog2(VEC_W / 8 + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             valid_i = 1'b0, sub_i = 1'b0, lane_wide_i = 1'b0, flag_clr_i = 1'b0;
    logic [BW-1:0]    act_bytes_i = '0, max_bytes_i = '0;
    logic [VEC_W-1:0] op_a_i = '0, op_b_i = '0, acc_i = '0;
    logic [VEC_W-1:0] res_o;
    logic             res_vld_o, sat_flag_o;

    int errors = 0;
    int checks = 0;
    bit exp_flag = 1'b0;

    always #2 clk = ~clk;

    sat_dmac_vec #(.VEC_W(VEC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .sub_i(sub_i),
        .lane_wide_i(lane_wide_i), .act_bytes_i(act_bytes_i), .max_bytes_i(max_bytes_i),
        .op_a_i(op_a_i), .op_b_i(op_b_i), .acc_i(acc_i), .flag_clr_i(flag_clr_i),
        .res_o(res_o), .res_vld_o(res_vld_o), .sat_flag_o(sat_flag_o)
    );

    task automatic chk(string req, logic [VEC_W-1:0] act, logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference lane arithmetic at 128-bit precision.
    function automatic longint lane_ref(int w, longint a, longint b, longint acc,
                                        bit sub, output bit sat);
        logic signed [127:0] p, s, sh, pmax, nmin;
        p    = 128'(a) * 128'(b);
        s    = (128'(acc) <<< (w - 1));
        s    = sub ? (s - p) : (s + p);
        s    = s + (128'sd1 <<< (w - 2));
        sh   = s >>> (w - 1);
        pmax = (128'sd1 <<< (w - 1)) - 1;
        nmin = -(128'sd1 <<< (w - 1));
        sat  = 1'b0;
        if (sh > pmax) begin sh = pmax; sat = 1'b1; end
        if (sh < nmin) begin sh = nmin; sat = 1'b1; end
        return longint'(sh);
    endfunction

    // Reference vector: per-chunk region, lanes, flag contribution.
    function automatic logic [VEC_W-1:0] vec_ref(logic [VEC_W-1:0] a, logic [VEC_W-1:0] b,
        logic [VEC_W-1:0] acc, bit sub, bit wide, int act, int mx, output bit sat);
        logic [VEC_W-1:0] r;
        bit s;
        longint v;
        sat = 1'b0;
        r = '0;
        for (int k = 0; k < VEC_W / 64; k++) begin
            if (k * 8 < act) begin
                if (wide) begin
                    for (int l = 0; l < 2; l++) begin
                        v = lane_ref(32, longint'($signed(a[k*64+l*32 +: 32])),
                                     longint'($signed(b[k*64+l*32 +: 32])),
                                     longint'($signed(acc[k*64+l*32 +: 32])), sub, s);
                        r[k*64+l*32 +: 32] = v[31:0];
                        sat |= s;
                    end
                end else begin
                    for (int l = 0; l < 4; l++) begin
                        v = lane_ref(16, longint'($signed(a[k*64+l*16 +: 16])),
                                     longint'($signed(b[k*64+l*16 +: 16])),
                                     longint'($signed(acc[k*64+l*16 +: 16])), sub, s);
                        r[k*64+l*16 +: 16] = v[15:0];
                        sat |= s;
                    end
                end
            end else if (k * 8 < mx) begin
                r[k*64 +: 64] = '0;
            end else begin
                r[k*64 +: 64] = acc[k*64 +: 64];
            end
        end
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] rnd_vec();
        logic [VEC_W-1:0] v;
        for (int i = 0; i < VEC_W / 16; i++) begin
            case ($urandom_range(0, 7))
                0: v[i*16 +: 16] = 16'h8000;
                1: v[i*16 +: 16] = 16'h7fff;
                default: v[i*16 +: 16] = 16'($urandom);
            endcase
        end
        return v;
    endfunction

    // Drive one request at a falling edge and check the registered outputs one cycle later.
    task automatic do_op(string req, logic [VEC_W-1:0] a, logic [VEC_W-1:0] b,
        logic [VEC_W-1:0] acc, bit sub, bit wide, int act, int mx, bit clr);
        logic [VEC_W-1:0] exp;
        bit s;
        exp = vec_ref(a, b, acc, sub, wide, act, mx, s);
        op_a_i = a; op_b_i = b; acc_i = acc; sub_i = sub; lane_wide_i = wide;
        act_bytes_i = BW'(act); max_bytes_i = BW'(mx); flag_clr_i = clr; valid_i = 1'b1;
        exp_flag = (clr ? 1'b0 : exp_flag) | s;
        @(negedge clk);
        valid_i = 1'b0; flag_clr_i = 1'b0;
        chk({req, " result"}, res_o, exp);
        chk("R10 valid", VEC_W'(res_vld_o), VEC_W'(1));
        chk({req, " R6 flag"}, VEC_W'(sat_flag_o), VEC_W'(exp_flag));
    endtask

    task automatic clear_flag();
        flag_clr_i = 1'b1;
        @(negedge clk);
        flag_clr_i = 1'b0;
        exp_flag = 1'b0;
        chk("R7 clear", VEC_W'(sat_flag_o), VEC_W'(0));
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [VEC_W-1:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 res", res_o, '0);
        chk("R11 vld", VEC_W'(res_vld_o), VEC_W'(0));
        chk("R11 flag", VEC_W'(sat_flag_o), VEC_W'(0));

        // R1 simple add, no clamp
        do_op("R1", {8{16'd3}}, {8{16'd5}}, {8{16'h0010}}, 0, 0, 16, 16, 0);
        // R5 distinct lane values
        do_op("R5", 128'h0001_0002_0003_0004_0005_0006_0007_0008,
              128'h4000_c000_2000_e000_7fff_0100_8001_1234,
              128'h0000_0001_fff0_0002_0100_ffff_0003_0004, 0, 0, 16, 16, 0);
        // R3 double-minimum corner, add saturates
        do_op("R3 add corner", {8{16'h8000}}, {8{16'h8000}}, '0, 0, 0, 16, 16, 0);
        chk("R3 lane value", VEC_W'(res_o[15:0]), VEC_W'(16'h7fff));
        clear_flag();
        // R2/R3 subtract corner: exact 0x8000, no clamp
        do_op("R2 sub corner", {8{16'h8000}}, {8{16'h8000}}, '0, 1, 0, 16, 16, 0);
        chk("R3 no clamp on sub", VEC_W'({sat_flag_o, res_o[15:0]}), VEC_W'({1'b0, 16'h8000}));
        // R4 32-bit corners
        do_op("R4 add corner", {4{32'h8000_0000}}, {4{32'h8000_0000}}, '0, 0, 1, 16, 16, 0);
        do_op("R4 sub corner", {4{32'h8000_0000}}, {4{32'h8000_0000}}, '0, 1, 1, 16, 16, 0);
        // R7 clear and saturating request in the same cycle keeps flag set
        do_op("R7 same-cycle", {8{16'h8000}}, {8{16'h8000}}, '0, 0, 0, 16, 16, 1);
        chk("R7 flag kept", VEC_W'(sat_flag_o), VEC_W'(1));
        clear_flag();
        // R8 saturating data only in zeroed chunk
        do_op("R8 zero tail", {{4{16'h8000}}, 64'd0}, {{4{16'h8000}}, 64'd0}, '0, 0, 0, 8, 16, 0);
        chk("R8 flag stays clear", VEC_W'(sat_flag_o), VEC_W'(0));
        // R9 saturating data only in kept chunk
        do_op("R9 keep tail", {{4{16'h8000}}, 64'd0}, {{4{16'h8000}}, 64'd0},
              {64'hdead_beef_0123_4567, 64'd0}, 0, 0, 8, 8, 0);
        chk("R9 flag stays clear", VEC_W'(sat_flag_o), VEC_W'(0));
        do_op("R8 R9 all inactive", rnd_vec(), rnd_vec(), rnd_vec(), 1, 1, 0, 8, 0);
        // R10 hold while idle
        held = res_o;
        @(negedge clk);
        chk("R10 hold", res_o, held);
        chk("R10 vld low", VEC_W'(res_vld_o), VEC_W'(0));

        // Random mix
        for (int n = 0; n < 400; n++) begin
            int act, mx;
            bit sub, wide;
            act  = 8 * $urandom_range(0, 2);
            mx   = act + 8 * $urandom_range(0, 2 - act / 8);
            sub  = 1'($urandom_range(0, 1));
            wide = 1'($urandom_range(0, 1));
            do_op(wide ? "R4 rand" : (sub ? "R2 rand" : "R1 rand"),
                  rnd_vec(), rnd_vec(), rnd_vec(), sub, wide, act, mx,
                  ($urandom_range(0, 9) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule